// File: doc/BRIEF.md
# Trap Entry Sequencer with Delegation

This block performs the architectural side of taking a trap in a processor with machine, supervisor and user privilege levels. A trap request carries a cause word, whose top bit marks an interrupt, together with the faulting PC and an optional bad address. In one clock edge the block decides where the trap is handled, computes the handler PC, and writes the cause, exception-PC and bad-address registers of the chosen level. It also stacks the interrupt-enable bits and the previous privilege into the status fields, and sets the new privilege level. A breakpoint can be sent to debug mode instead, enabled separately for each privilege level. While a debug cause is recorded, any other trap only redirects the PC to a fixed debug-exception address.

Trap requests arrive on a valid/ready stream. `trap_ready` is high except in a cycle where a state write (`st_wr`) is presented. A state write loads the privilege, SIE and MIE, and can clear the recorded debug cause. A request is taken on a rising edge where `trap_valid` and `trap_ready` are both high. While `trap_ready` is low the requester must hold the request unchanged. All results are registered and appear in the cycle after acceptance, marked by a one-cycle `pc_vld` pulse. A one-cycle `flush` pulse tells translation logic that the privilege level has changed.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the privilege is M (encoding U=0, S=1, H=2, M=3). All status bits, cause, EPC, bad-address and debug registers are zero, and `pc_vld` and `flush` are low.
- R2: `trap_ready` is low in any cycle with `st_wr` high, and a request presented then is not taken. An accepted request produces `pc_vld` high for exactly the following cycle, and no `pc_vld` appears without one.
- R3: A trap goes to S only when the current privilege is U or S, the cause index (cause with bit XLEN-1 cleared) is below XLEN, and the bit of the delegation mask at that index is set. The mask is `mideleg` for interrupts (bit XLEN-1 set) and `medeleg` for exceptions. Every other trap goes to M.
- R4: S entry sets the PC to `stvec` and writes `scause` and `sepc`. It copies SIE into SPIE, stores bit 0 of the old privilege in SPP, clears SIE and sets the privilege to S. The M cause, EPC and bad-address registers are left untouched.
- R5: M entry writes `mcause` and `mepc`. It copies MIE into MPIE, stores the old privilege in MPP, clears MIE and sets the privilege to M.
- R6: The M handler PC is `mtvec` with bit 0 cleared. Four times the cause index is added only when `mtvec` bit 0 is set and the trap is an interrupt.
- R7: The bad-address register of the entered level is written only when `trap_bad_vld` is high. Otherwise it keeps its value.
- R8: An exception with cause index 3 (breakpoint) enters debug mode when `brk_en[priv]` is set. Debug entry sets the debug cause to 1, stores the old privilege in `dbg_prv`, stores the EPC in `dpc`, switches to M and jumps to `DBG_ROM_ADDR`. Machine and supervisor registers are untouched. With the enable clear, the breakpoint is handled as a normal trap.
- R9: While the debug cause is non-zero, any trap that does not qualify under R8 sets the PC to `DBG_EXC_ADDR` and changes no other state.
- R10: `flush` is high for exactly the one cycle in which the privilege register holds a new value, whether changed by a trap or by a state write, and low otherwise.
- R11: A state write loads `st_sie`, `st_mie` and the privilege, storing a requested H as U. With `st_dbg_clr` high it also clears the debug cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_valid | input | 1 | Trap request valid |
| trap_ready | output | 1 | Trap request can be taken |
| trap_cause | input | XLEN | Cause word; top bit marks an interrupt |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_bad_vld | input | 1 | Bad address is valid |
| trap_bad | input | XLEN | Bad address |
| st_wr | input | 1 | State write strobe |
| st_priv | input | 2 | Privilege to load |
| st_sie | input | 1 | SIE value to load |
| st_mie | input | 1 | MIE value to load |
| st_dbg_clr | input | 1 | Clear the debug cause on a state write |
| mtvec | input | XLEN | Machine vector base; bit 0 selects vectored interrupts |
| stvec | input | XLEN | Supervisor vector |
| medeleg | input | XLEN | Exception delegation mask |
| mideleg | input | XLEN | Interrupt delegation mask |
| brk_en | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| pc_vld | output | 1 | Handler PC valid pulse |
| pc_tgt | output | XLEN | Handler PC |
| priv | output | 2 | Current privilege |
| flush | output | 1 | Privilege change pulse |
| sie | output | 1 | Supervisor interrupt enable |
| spie | output | 1 | Supervisor previous interrupt enable |
| spp | output | 1 | Supervisor previous privilege |
| mie | output | 1 | Machine interrupt enable |
| mpie | output | 1 | Machine previous interrupt enable |
| mpp | output | 2 | Machine previous privilege |
| mcause | output | XLEN | Machine cause |
| mepc | output | XLEN | Machine exception PC |
| mbad | output | XLEN | Machine bad address |
| scause | output | XLEN | Supervisor cause |
| sepc | output | XLEN | Supervisor exception PC |
| sbad | output | XLEN | Supervisor bad address |
| dbg_cause | output | 3 | Recorded debug cause |
| dbg_prv | output | 2 | Privilege before debug entry |
| dpc | output | XLEN | Debug PC |

## Verification
The bench builds the block with XLEN = 32, a debug ROM at 0x800 and a debug-exception address at 0x808. With a 32-bit word, an exception index of 40 aliases to delegation bit 8 when truncated to five bits. A plain truncation would therefore send that trap to S, so the range check of R3 is observable. The 32-bit width also lets interrupt index 7 in vectored mode land on a distinct offset of 0x1C. Both debug addresses differ from every vector used, so the debug-entry and debug-exception routes are told apart by the PC alone.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_H = 2'd2;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam logic [2:0] DBG_WHY_SWBP = 3'd1;

  typedef enum logic [1:0] {
    RT_M         = 2'd0,
    RT_S         = 2'd1,
    RT_DBG_ENTER = 2'd2,
    RT_DBG_EXC   = 2'd3
  } route_e;
endpackage

// File: rtl/trap_router.sv
module trap_router
  import trap_seq_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int BRK_CAUSE = 3
) (
  input  logic [XLEN-1:0] cause,
  input  logic [1:0]      cur_priv,
  input  logic [3:0]      brk_en,
  input  logic            dbg_active,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] mideleg,
  output route_e          route,
  output logic            is_irq,
  output logic [XLEN-2:0] idx
);
  localparam int IW = $clog2(XLEN);

  logic [XLEN-1:0] deleg;
  logic            in_range;
  logic            deleg_hit;
  logic            brk_hit;

  assign is_irq    = cause[XLEN-1];
  assign idx       = cause[XLEN-2:0];
  assign deleg     = is_irq ? mideleg : medeleg;
  // the index must be checked against XLEN before low bits pick a mask bit
  assign in_range  = idx < (XLEN-1)'(XLEN);
  assign deleg_hit = in_range && deleg[idx[IW-1:0]];
  assign brk_hit   = !is_irq && (idx == (XLEN-1)'(BRK_CAUSE)) && brk_en[cur_priv];

  always_comb begin
    if (brk_hit)                              route = RT_DBG_ENTER;
    else if (dbg_active)                      route = RT_DBG_EXC;
    else if ((cur_priv <= PRV_S) && deleg_hit) route = RT_S;
    else                                      route = RT_M;
  end
endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_seq_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter logic [XLEN-1:0] DBG_ROM_ADDR = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC_ADDR = 'h808
) (
  input  route_e          route,
  input  logic            is_irq,
  input  logic [XLEN-2:0] idx,
  input  logic [XLEN-1:0] mtvec,
  input  logic [XLEN-1:0] stvec,
  output logic [XLEN-1:0] pc
);
  logic [XLEN-1:0] m_base;
  logic [XLEN-1:0] m_off;

  assign m_base = {mtvec[XLEN-1:1], 1'b0};
  assign m_off  = (mtvec[0] && is_irq) ? XLEN'({idx, 2'b00}) : '0;

  always_comb begin
    unique case (route)
      RT_S:         pc = stvec;
      RT_DBG_ENTER: pc = DBG_ROM_ADDR;
      RT_DBG_EXC:   pc = DBG_EXC_ADDR;
      default:      pc = m_base + m_off;
    endcase
  end
endmodule

// File: rtl/trap_arch_state.sv
module trap_arch_state
  import trap_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  route_e          route,
  input  logic [XLEN-1:0] tgt,
  input  logic [XLEN-1:0] cause,
  input  logic [XLEN-1:0] epc,
  input  logic            bad_vld,
  input  logic [XLEN-1:0] bad,
  input  logic            st_wr,
  input  logic [1:0]      st_priv,
  input  logic            st_sie,
  input  logic            st_mie,
  input  logic            st_dbg_clr,
  output logic            pc_vld,
  output logic [XLEN-1:0] pc_tgt,
  output logic [1:0]      priv,
  output logic            flush,
  output logic            sie,
  output logic            spie,
  output logic            spp,
  output logic            mie,
  output logic            mpie,
  output logic [1:0]      mpp,
  output logic [XLEN-1:0] mcause,
  output logic [XLEN-1:0] mepc,
  output logic [XLEN-1:0] mbad,
  output logic [XLEN-1:0] scause,
  output logic [XLEN-1:0] sepc,
  output logic [XLEN-1:0] sbad,
  output logic [2:0]      dbg_cause,
  output logic [1:0]      dbg_prv,
  output logic [XLEN-1:0] dpc
);
  logic [1:0] priv_nx;

  always_comb begin
    priv_nx = priv;
    if (fire) begin
      unique case (route)
        RT_S:       priv_nx = PRV_S;
        RT_DBG_EXC: priv_nx = priv;
        default:    priv_nx = PRV_M;
      endcase
    end else if (st_wr) begin
      priv_nx = (st_priv == PRV_H) ? PRV_U : st_priv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_vld    <= 1'b0;
      pc_tgt    <= '0;
      priv      <= PRV_M;
      flush     <= 1'b0;
      sie       <= 1'b0;
      spie      <= 1'b0;
      spp       <= 1'b0;
      mie       <= 1'b0;
      mpie      <= 1'b0;
      mpp       <= 2'd0;
      mcause    <= '0;
      mepc      <= '0;
      mbad      <= '0;
      scause    <= '0;
      sepc      <= '0;
      sbad      <= '0;
      dbg_cause <= '0;
      dbg_prv   <= 2'd0;
      dpc       <= '0;
    end else begin
      pc_vld <= fire;
      flush  <= (priv_nx != priv);
      priv   <= priv_nx;
      if (fire) begin
        pc_tgt <= tgt;
        unique case (route)
          RT_S: begin
            scause <= cause;
            sepc   <= epc;
            if (bad_vld) sbad <= bad;
            spie   <= sie;
            spp    <= priv[0];
            sie    <= 1'b0;
          end
          RT_M: begin
            mcause <= cause;
            mepc   <= epc;
            if (bad_vld) mbad <= bad;
            mpie   <= mie;
            mpp    <= priv;
            mie    <= 1'b0;
          end
          RT_DBG_ENTER: begin
            dbg_cause <= DBG_WHY_SWBP;
            dbg_prv   <= priv;
            dpc       <= epc;
          end
          default: ;
        endcase
      end else if (st_wr) begin
        sie <= st_sie;
        mie <= st_mie;
        if (st_dbg_clr) dbg_cause <= '0;
      end
    end
  end

  // R2: one pc_vld pulse per accepted request, none otherwise
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pc_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !pc_vld);
  // R4: supervisor entry stacking
  a_r4_s_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && route == RT_S) |=> (priv == PRV_S && !sie && spie == $past(sie)
                                 && $stable(mcause)));
  // R5: machine entry stacking
  a_r5_m_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && route == RT_M) |=> (priv == PRV_M && !mie && mpie == $past(mie)
                                 && mpp == $past(priv)));
  // R8: debug entry records cause and moves to M
  a_r8_dbg_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && route == RT_DBG_ENTER) |=> (dbg_cause == DBG_WHY_SWBP && priv == PRV_M
                                         && $stable(mepc) && $stable(sepc)));
  // R9: debug exception leaves architectural state alone
  a_r9_dbg_exc: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && route == RT_DBG_EXC) |=> ($stable(priv) && $stable(mcause)
                                       && $stable(scause) && $stable(mie)));
  // R10: flush marks exactly the cycles with a new privilege
  a_r10_flush_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (priv != $past(priv)) |-> flush);
  a_r10_flush_only_change: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (priv != $past(priv)));
  // R11: a requested H privilege never becomes visible
  a_r11_no_h: assert property (@(posedge clk) disable iff (!rst_n)
    priv != PRV_H);
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter int              BRK_CAUSE    = 3,
  parameter logic [XLEN-1:0] DBG_ROM_ADDR = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC_ADDR = 'h808
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  output logic            trap_ready,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic            trap_bad_vld,
  input  logic [XLEN-1:0] trap_bad,
  input  logic            st_wr,
  input  logic [1:0]      st_priv,
  input  logic            st_sie,
  input  logic            st_mie,
  input  logic            st_dbg_clr,
  input  logic [XLEN-1:0] mtvec,
  input  logic [XLEN-1:0] stvec,
  input  logic [XLEN-1:0] medeleg,
  input  logic [XLEN-1:0] mideleg,
  input  logic [3:0]      brk_en,
  output logic            pc_vld,
  output logic [XLEN-1:0] pc_tgt,
  output logic [1:0]      priv,
  output logic            flush,
  output logic            sie,
  output logic            spie,
  output logic            spp,
  output logic            mie,
  output logic            mpie,
  output logic [1:0]      mpp,
  output logic [XLEN-1:0] mcause,
  output logic [XLEN-1:0] mepc,
  output logic [XLEN-1:0] mbad,
  output logic [XLEN-1:0] scause,
  output logic [XLEN-1:0] sepc,
  output logic [XLEN-1:0] sbad,
  output logic [2:0]      dbg_cause,
  output logic [1:0]      dbg_prv,
  output logic [XLEN-1:0] dpc
);
  route_e          route;
  logic            is_irq;
  logic [XLEN-2:0] idx;
  logic [XLEN-1:0] tgt;
  logic            fire;

  // a state write owns the cycle; the request waits
  assign trap_ready = !st_wr;
  assign fire       = trap_valid && trap_ready;

  trap_router #(.XLEN(XLEN), .BRK_CAUSE(BRK_CAUSE)) u_router (
    .cause      (trap_cause),
    .cur_priv   (priv),
    .brk_en     (brk_en),
    .dbg_active (dbg_cause != 3'd0),
    .medeleg    (medeleg),
    .mideleg    (mideleg),
    .route      (route),
    .is_irq     (is_irq),
    .idx        (idx)
  );

  trap_target #(.XLEN(XLEN), .DBG_ROM_ADDR(DBG_ROM_ADDR), .DBG_EXC_ADDR(DBG_EXC_ADDR)) u_target (
    .route  (route),
    .is_irq (is_irq),
    .idx    (idx),
    .mtvec  (mtvec),
    .stvec  (stvec),
    .pc     (tgt)
  );

  trap_arch_state #(.XLEN(XLEN)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .route      (route),
    .tgt        (tgt),
    .cause      (trap_cause),
    .epc        (trap_epc),
    .bad_vld    (trap_bad_vld),
    .bad        (trap_bad),
    .st_wr      (st_wr),
    .st_priv    (st_priv),
    .st_sie     (st_sie),
    .st_mie     (st_mie),
    .st_dbg_clr (st_dbg_clr),
    .pc_vld     (pc_vld),
    .pc_tgt     (pc_tgt),
    .priv       (priv),
    .flush      (flush),
    .sie        (sie),
    .spie       (spie),
    .spp        (spp),
    .mie        (mie),
    .mpie       (mpie),
    .mpp        (mpp),
    .mcause     (mcause),
    .mepc       (mepc),
    .mbad       (mbad),
    .scause     (scause),
    .sepc       (sepc),
    .sbad       (sbad),
    .dbg_cause  (dbg_cause),
    .dbg_prv    (dbg_prv),
    .dpc        (dpc)
  );

  // R3: supervisor routing only from U or S
  a_r3_s_from_low: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && route == RT_S) |-> (priv <= PRV_S));
  // R2: no request is taken while a state write is presented
  a_r2_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && trap_valid) |=> !pc_vld);
  // R6: non-vectored or exception entry lands on the aligned base
  a_r6_m_base: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && route == RT_M && !(mtvec[0] && is_irq)) |=> (pc_tgt == {$past(mtvec[XLEN-1:1]), 1'b0}));
endmodule

// File: tb/test_trap_entry_seq.sv
`timescale 1ns/1ps
module test_trap_entry_seq;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_valid = 0, trap_bad_vld = 0;
  logic [31:0] trap_cause = 0, trap_epc = 0, trap_bad = 0;
  logic st_wr = 0, st_sie = 0, st_mie = 0, st_dbg_clr = 0;
  logic [1:0] st_priv = 0;
  logic [31:0] mtvec = 32'h8000_0101, stvec = 32'h4000_0200;
  logic [31:0] medeleg = 32'h0000_0100, mideleg = 32'h0000_0022;
  logic [3:0] brk_en = 4'b0000;
  logic trap_ready, pc_vld, flush, sie, spie, spp, mie, mpie;
  logic [31:0] pc_tgt, mcause, mepc, mbad, scause, sepc, sbad, dpc;
  logic [1:0] priv, mpp, dbg_prv;
  logic [2:0] dbg_cause;

  int checks = 0;
  int errors = 0;
  logic [1:0] eff;

  always #2.5 clk = ~clk;

  trap_entry_seq #(.XLEN(XLEN), .DBG_ROM_ADDR(32'h800), .DBG_EXC_ADDR(32'h808)) i_trap_entry_seq (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_cause(trap_cause), .trap_epc(trap_epc), .trap_bad_vld(trap_bad_vld), .trap_bad(trap_bad),
    .st_wr(st_wr), .st_priv(st_priv), .st_sie(st_sie), .st_mie(st_mie), .st_dbg_clr(st_dbg_clr),
    .mtvec(mtvec), .stvec(stvec), .medeleg(medeleg), .mideleg(mideleg), .brk_en(brk_en),
    .pc_vld(pc_vld), .pc_tgt(pc_tgt), .priv(priv), .flush(flush),
    .sie(sie), .spie(spie), .spp(spp), .mie(mie), .mpie(mpie), .mpp(mpp),
    .mcause(mcause), .mepc(mepc), .mbad(mbad), .scause(scause), .sepc(sepc), .sbad(sbad),
    .dbg_cause(dbg_cause), .dbg_prv(dbg_prv), .dpc(dpc)
  );

  typedef struct packed {
    logic [1:0]  pv;
    logic [31:0] cause;
    logic [31:0] pc;
    logic [1:0]  pr;
  } row_t;

  localparam int NROWS = 11;
  localparam row_t ROWS [NROWS] = '{
    '{2'd0, 32'h0000_0008, 32'h4000_0200, 2'd1},
    '{2'd1, 32'h0000_0008, 32'h4000_0200, 2'd1},
    '{2'd3, 32'h0000_0008, 32'h8000_0100, 2'd3},
    '{2'd0, 32'h8000_0005, 32'h4000_0200, 2'd1},
    '{2'd0, 32'h8000_0007, 32'h8000_011C, 2'd3},
    '{2'd3, 32'h8000_0007, 32'h8000_011C, 2'd3},
    '{2'd0, 32'h0000_0002, 32'h8000_0100, 2'd3},
    '{2'd1, 32'h0000_0005, 32'h8000_0100, 2'd3},
    '{2'd0, 32'h0000_0028, 32'h8000_0100, 2'd3},
    '{2'd1, 32'h8000_0001, 32'h4000_0200, 2'd1},
    '{2'd2, 32'h0000_0008, 32'h4000_0200, 2'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_state(input logic [1:0] p, input logic s, input logic m, input logic d);
    @(negedge clk);
    st_wr = 1'b1; st_priv = p; st_sie = s; st_mie = m; st_dbg_clr = d;
    @(negedge clk);
    st_wr = 1'b0; st_dbg_clr = 1'b0;
  endtask

  task automatic fire_trap(input logic [31:0] c, input logic [31:0] e, input logic bv, input logic [31:0] b);
    @(negedge clk);
    trap_valid = 1'b1; trap_cause = c; trap_epc = e; trap_bad_vld = bv; trap_bad = b;
    @(negedge clk);
    trap_valid = 1'b0; trap_bad_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 priv", 32'(priv), 32'd3);
    chk("R1 pc_vld", 32'(pc_vld), 32'd0);
    chk("R1 flush", 32'(flush), 32'd0);
    chk("R1 status", {26'd0, sie, spie, spp, mie, mpie, 1'b0}, 32'd0);
    chk("R1 mcause", mcause, 32'd0);
    chk("R1 dbg_cause", 32'(dbg_cause), 32'd0);

    // R2: request presented together with a state write is held off
    @(negedge clk);
    st_wr = 1'b1; st_priv = 2'd0; st_sie = 1'b1; st_mie = 1'b1;
    trap_valid = 1'b1; trap_cause = 32'h2; trap_epc = 32'h50;
    #1;
    chk("R2 ready low", 32'(trap_ready), 32'd0);
    @(negedge clk);
    st_wr = 1'b0; trap_valid = 1'b0;
    chk("R2 no pc_vld", 32'(pc_vld), 32'd0);
    chk("R2 mcause kept", mcause, 32'd0);
    chk("R11 priv loaded", 32'(priv), 32'd0);
    chk("R11 sie mie loaded", {30'd0, sie, mie}, 32'd3);
    chk("R10 flush on write", 32'(flush), 32'd1);
    @(negedge clk);
    chk("R10 flush one cycle", 32'(flush), 32'd0);

    // table walk: R3 R4 R5 R6 R10 R11
    for (int i = 0; i < NROWS; i++) begin
      eff = (ROWS[i].pv == 2'd2) ? 2'd0 : ROWS[i].pv;
      write_state(ROWS[i].pv, 1'b1, 1'b1, 1'b0);
      fire_trap(ROWS[i].cause, 32'h1000 + 32'(i) * 4, 1'b0, 32'h0);
      chk($sformatf("R2 row %0d pc_vld", i), 32'(pc_vld), 32'd1);
      chk($sformatf("R6 R3 row %0d pc", i), pc_tgt, ROWS[i].pc);
      chk($sformatf("R3 row %0d priv", i), 32'(priv), 32'(ROWS[i].pr));
      chk($sformatf("R10 row %0d flush", i), 32'(flush), 32'(ROWS[i].pr != eff));
      if (ROWS[i].pr == 2'd1) begin
        chk($sformatf("R4 row %0d sie spie spp", i), {29'd0, sie, spie, spp}, {29'd0, 1'b0, 1'b1, eff[0]});
        chk($sformatf("R4 row %0d scause", i), scause, ROWS[i].cause);
        chk($sformatf("R4 row %0d sepc", i), sepc, 32'h1000 + 32'(i) * 4);
      end else begin
        chk($sformatf("R5 row %0d mie mpie mpp", i), {28'd0, mie, mpie, mpp}, {28'd0, 1'b0, 1'b1, eff});
        chk($sformatf("R5 row %0d mcause", i), mcause, ROWS[i].cause);
        chk($sformatf("R5 row %0d mepc", i), mepc, 32'h1000 + 32'(i) * 4);
      end
    end
    chk("R4 mcause untouched by S", mcause, 32'h0000_0028);

    // R8: breakpoint with its enable clear is a normal trap
    brk_en = 4'b0000;
    write_state(2'd1, 1'b1, 1'b1, 1'b0);
    fire_trap(32'h3, 32'h1111, 1'b0, 32'h0);
    chk("R8 disabled pc", pc_tgt, 32'h8000_0100);
    chk("R8 disabled dbg_cause", 32'(dbg_cause), 32'd0);
    chk("R8 disabled mepc", mepc, 32'h1111);

    // R8: enabled for S
    brk_en = 4'b0010;
    write_state(2'd1, 1'b1, 1'b1, 1'b0);
    fire_trap(32'h3, 32'h2222, 1'b0, 32'h0);
    chk("R8 pc", pc_tgt, 32'h800);
    chk("R8 priv", 32'(priv), 32'd3);
    chk("R8 dbg_cause", 32'(dbg_cause), 32'd1);
    chk("R8 dbg_prv", 32'(dbg_prv), 32'd1);
    chk("R8 dpc", dpc, 32'h2222);
    chk("R8 mepc untouched", mepc, 32'h1111);
    chk("R10 flush on debug entry", 32'(flush), 32'd1);

    // R9: trap while the debug cause is recorded
    fire_trap(32'h2, 32'h3333, 1'b1, 32'hAAAA_0000);
    chk("R9 pc", pc_tgt, 32'h808);
    chk("R9 priv", 32'(priv), 32'd3);
    chk("R9 mepc untouched", mepc, 32'h1111);
    chk("R9 mbad untouched", mbad, 32'h0);
    chk("R9 flush low", 32'(flush), 32'd0);
    chk("R9 pc_vld", 32'(pc_vld), 32'd1);

    // R11: debug clear through a state write
    write_state(2'd1, 1'b0, 1'b0, 1'b1);
    chk("R11 dbg cleared", 32'(dbg_cause), 32'd0);
    fire_trap(32'h2, 32'h4444, 1'b0, 32'h0);
    chk("R11 normal entry after clear", pc_tgt, 32'h8000_0100);
    chk("R5 mpp from S", 32'(mpp), 32'd1);

    // R7: bad address only with its valid flag
    fire_trap(32'h2, 32'h5555, 1'b1, 32'hDEAD_BEEF);
    chk("R7 mbad written", mbad, 32'hDEAD_BEEF);
    fire_trap(32'h4, 32'h6666, 1'b0, 32'h1234_5678);
    chk("R7 mbad kept", mbad, 32'hDEAD_BEEF);
    chk("R7 mcause", mcause, 32'h4);
    write_state(2'd0, 1'b0, 1'b0, 1'b0);
    fire_trap(32'h8, 32'h7777, 1'b1, 32'h0000_1234);
    chk("R7 sbad written", sbad, 32'h0000_1234);
    chk("R7 mbad not hit by S", mbad, 32'hDEAD_BEEF);

    // R6: vectoring off
    mtvec = 32'h8000_0100;
    write_state(2'd0, 1'b1, 1'b1, 1'b0);
    fire_trap(32'h8000_0007, 32'h8888, 1'b0, 32'h0);
    chk("R6 non-vectored interrupt", pc_tgt, 32'h8000_0100);
    @(negedge clk);
    chk("R2 pc_vld single cycle", 32'(pc_vld), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule